// File: doc/BRIEF.md
# Pulse-and-Verify Memory Programming Sequencer

This block sits in a device programmer and writes a run of bytes into an erasable, byte-wide programmable memory. It works through the addresses from zero to the last one. At each address it fetches the byte from a data source over a request/acknowledge link. A byte of all ones is already the erased value, so it is passed over. For any other byte the block applies program pulses of fixed width. After each pulse it reads the cell back, and it keeps pulsing until the cell matches or the try limit runs out. A matching cell then gets one extra pulse whose length scales with the number of tries it needed.

After the last address the block switches the programming supply off. It then reads the whole array back twice: once with the core supply still at its programming level, and once with the core supply lowered. Each comparison byte is fetched again from the source. The block drives the memory's address, data, chip enable, output enable and program strobe lines directly. It also raises digital requests that an external supply circuit turns into voltages. When it finishes it reports pass or fail, and on a fail it holds the address that failed first.

All times are counted in clock cycles and set by parameters: settle time, pulse width, read access and the try limit.

Top module: `prog_seq`

## Requirements
- R1: While idle after reset, chip enable, output enable and program strobe are high (inactive), the data driver is off, the programming supply request is off, the core supply select is 2'b00 (nominal), and busy, done, fail and src_req are low.
- R2: The core supply select is 2'b01 (programming level) for at least SETUP_CYC cycles before the programming supply request rises. It stays at 2'b01 for the whole time that request is high. It keeps that value for at least SETUP_CYC cycles after the request falls.
- R3: Address, write data, data drive, chip enable and both supply requests are unchanged for at least SETUP_CYC cycles before the program strobe falls. While the strobe is low, chip enable is low, the data driver is on and the programming supply request is on.
- R4: The try count starts at 1 for every address that is programmed. Each normal pulse holds the strobe low for exactly PULSE_CYC cycles, and a read-back verify follows every normal pulse.
- R5: After a pulse ends, write data stays driven for more than SETUP_CYC cycles. Output enable does not fall until more than 2*SETUP_CYC cycles after the strobe rises. The data driver is never on while output enable is low. The driver turns on again only more than READ_CYC cycles after output enable rises.
- R6: When a verify misses, the try count goes up by one and another pulse follows. If the verify after pulse number MAX_TRIES still misses, the block stops programming and fails. It then issues exactly MAX_TRIES pulses to that address and none to any later address.
- R7: After a verify matches on try n, one extra pulse of exactly OVER_MULT*n*PULSE_CYC cycles is applied, and then the block moves to the next address.
- R8: A source byte equal to all ones (8'hFF) gets no program pulse.
- R9: After programming, every address is read back and compared, first with the core select at 2'b01 and then at 2'b10 (low level). The programming supply request stays off throughout. Any mismatch fails the run.
- R10: On completion, done is high, the programming supply request is off and the core select is back at 2'b00. pass is high only if no failure happened. fail stays high with fail_addr holding the first failing address until the next start.
- R11: src_req stays high with mem_addr unchanged until src_ack. The byte on src_data is taken on the cycle of src_ack. Each run makes one fetch per address for programming and one per address in each check pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when idle or finished |
| src_req | output | 1 | Request for the byte at mem_addr |
| src_ack | input | 1 | Source answers; src_data valid |
| src_data | input | DATA_W | Byte from the source |
| mem_addr | output | ADDR_W | Memory address, also the source index |
| mem_wdata | output | DATA_W | Data driven into the memory |
| mem_drive | output | 1 | Enables the programmer's data driver |
| mem_rdata | input | DATA_W | Data read from the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_pgm_n | output | 1 | Program strobe, active low |
| vpp_on | output | 1 | Programming supply request |
| vcc_sel | output | 2 | Core supply select: 00 nominal, 01 program, 10 low |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run finished |
| pass | output | 1 | Run finished without failure |
| fail | output | 1 | A failure was seen in this run |
| fail_addr | output | ADDR_W | First failing address |

## Verification
The assertions rely on a few properties of the source. It answers each request exactly once, it raises acknowledge only while the request is high, and the byte it returns belongs to the address shown. They also rely on the memory's read data being settled within READ_CYC cycles of output enable falling. The bench meets these conditions with a responder that works on the falling clock edge and answers every other cycle from a table indexed by mem_addr. Its memory model is combinational, takes each cell from a byte array and sets a cell only after a chosen number of strobes. Supply-dependent weakness is modelled by flipping one bit of a chosen address when the core select is at the low level.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_PWR_VCC, S_PWR_VPP, S_FETCH, S_SETUP, S_PULSE, S_HOLD, S_RECOV,
    S_VERIFY, S_FLOAT, S_VPP_OFF, S_CFETCH, S_CREAD, S_VCC_LOW, S_VCC_NOM, S_END
  } seq_state_e;

  localparam logic [1:0] VCC_NOMINAL = 2'b00;
  localparam logic [1:0] VCC_PROGLVL = 2'b01;
  localparam logic [1:0] VCC_LOWLVL  = 2'b10;

endpackage

// File: rtl/prog_timer.sv
module prog_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  // R4: a running interval shrinks by exactly one per cycle
  p_timer_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - TW'(1)));

endmodule

// File: rtl/prog_attempt.sv
module prog_attempt #(
  parameter int MAX_TRIES = 25,
  parameter int NW        = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [NW-1:0] n,
  output logic          at_max
);

  logic [NW-1:0] n_q;
  logic [NW-1:0] n_d;
  logic          n_en;

  always_comb begin
    n_en = clr || inc;
    n_d  = clr ? NW'(1) : n_q + NW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    n_q <= NW'(1);
    else if (n_en) n_q <= n_d;
  end

  assign n      = n_q;
  assign at_max = (n_q == NW'(MAX_TRIES));

  p_try_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (n_q >= NW'(1)) && (n_q <= NW'(MAX_TRIES)));
  p_no_step_past_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    at_max |-> !(inc && !clr));

endmodule

// File: rtl/prog_addr.sv
module prog_addr #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [AW-1:0] addr,
  output logic          is_last
);

  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_d;
  logic          addr_en;

  always_comb begin
    addr_en = clr || inc;
    addr_d  = clr ? '0 : addr_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr    = addr_q;
  assign is_last = &addr_q;

  p_addr_no_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    is_last |-> !(inc && !clr));

endmodule

// File: rtl/prog_seq.sv
module prog_seq
  import prog_seq_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 8,
  parameter int SETUP_CYC = 400,
  parameter int PULSE_CYC = 200000,
  parameter int READ_CYC  = 20,
  parameter int MAX_TRIES = 25,
  parameter int OVER_MULT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              src_req,
  input  logic              src_ack,
  input  logic [DATA_W-1:0] src_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_drive,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_pgm_n,
  output logic              vpp_on,
  output logic [1:0]        vcc_sel,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr
);

  localparam int LEN_OVER = OVER_MULT * MAX_TRIES * PULSE_CYC;
  localparam int LEN_A    = (SETUP_CYC > READ_CYC) ? SETUP_CYC : READ_CYC;
  localparam int LEN_MAX  = (LEN_OVER > LEN_A) ? LEN_OVER : LEN_A;
  localparam int TW       = $clog2(LEN_MAX + 1);
  localparam int NW       = $clog2(MAX_TRIES + 1);
  localparam logic [TW-1:0] SET_LD    = TW'(SETUP_CYC - 1);
  localparam logic [TW-1:0] PUL_LD    = TW'(PULSE_CYC - 1);
  localparam logic [TW-1:0] RD_LD     = TW'(READ_CYC - 1);
  localparam logic [TW-1:0] OVER_UNIT = TW'(OVER_MULT * PULSE_CYC);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  seq_state_e        state_q, state_d;
  logic [DATA_W-1:0] data_q;
  logic              over_q, chk_lo_q, fail_q;
  logic [ADDR_W-1:0] fail_addr_q;

  logic              tmr_load, tmr_exp;
  logic [TW-1:0]     tmr_val;
  logic              try_clr, try_inc, try_max;
  logic [NW-1:0]     try_n;
  logic              ad_clr, ad_inc, ad_last;
  logic              data_en, over_set, over_clr, lo_set, lo_clr, fail_set, run_clr;
  logic [TW-1:0]     over_ld;
  logic              rd_match, is_erased;

  prog_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_core_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp));

  prog_attempt #(.MAX_TRIES(MAX_TRIES), .NW(NW)) u_attempt (
    .clk(clk), .rst_n(rst_core_n), .clr(try_clr), .inc(try_inc), .n(try_n), .at_max(try_max));

  prog_addr #(.AW(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_core_n), .clr(ad_clr), .inc(ad_inc), .addr(mem_addr), .is_last(ad_last));

  assign over_ld   = TW'(try_n) * OVER_UNIT - TW'(1);
  assign rd_match  = (mem_rdata == data_q);
  assign is_erased = (src_data == '1);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = SET_LD;
    try_clr  = 1'b0;
    try_inc  = 1'b0;
    ad_clr   = 1'b0;
    ad_inc   = 1'b0;
    data_en  = 1'b0;
    over_set = 1'b0;
    over_clr = 1'b0;
    lo_set   = 1'b0;
    lo_clr   = 1'b0;
    fail_set = 1'b0;
    run_clr  = 1'b0;
    unique case (state_q)
      S_IDLE, S_END: if (start) begin
        state_d = S_PWR_VCC; tmr_load = 1'b1; ad_clr = 1'b1; run_clr = 1'b1;
      end
      S_PWR_VCC: if (tmr_exp) begin state_d = S_PWR_VPP; tmr_load = 1'b1; end
      S_PWR_VPP: if (tmr_exp) state_d = S_FETCH;
      S_FETCH: if (src_ack) begin
        if (!is_erased) begin
          state_d = S_SETUP; tmr_load = 1'b1; data_en = 1'b1; try_clr = 1'b1; over_clr = 1'b1;
        end else if (ad_last) begin
          state_d = S_VPP_OFF; tmr_load = 1'b1;
        end else begin
          ad_inc = 1'b1;
        end
      end
      S_SETUP: if (tmr_exp) begin
        state_d = S_PULSE; tmr_load = 1'b1; tmr_val = over_q ? over_ld : PUL_LD;
      end
      S_PULSE: if (tmr_exp) begin state_d = S_HOLD; tmr_load = 1'b1; end
      S_HOLD: if (tmr_exp) begin
        tmr_load = 1'b1;
        if (!over_q)      state_d = S_RECOV;
        else if (ad_last) state_d = S_VPP_OFF;
        else begin state_d = S_FETCH; ad_inc = 1'b1; tmr_load = 1'b0; end
      end
      S_RECOV: if (tmr_exp) begin state_d = S_VERIFY; tmr_load = 1'b1; tmr_val = RD_LD; end
      S_VERIFY: if (tmr_exp) begin
        tmr_load = 1'b1;
        if (rd_match)     begin state_d = S_FLOAT; tmr_val = RD_LD; over_set = 1'b1; end
        else if (try_max) begin state_d = S_VPP_OFF; fail_set = 1'b1; end
        else              begin state_d = S_FLOAT; tmr_val = RD_LD; try_inc = 1'b1; end
      end
      S_FLOAT: if (tmr_exp) begin state_d = S_SETUP; tmr_load = 1'b1; end
      S_VPP_OFF: if (tmr_exp) begin
        if (fail_q) begin state_d = S_VCC_NOM; tmr_load = 1'b1; end
        else begin state_d = S_CFETCH; ad_clr = 1'b1; lo_clr = 1'b1; end
      end
      S_CFETCH: if (src_ack) begin
        state_d = S_CREAD; tmr_load = 1'b1; tmr_val = RD_LD; data_en = 1'b1;
      end
      S_CREAD: if (tmr_exp) begin
        if (!rd_match) begin
          state_d = S_VCC_NOM; tmr_load = 1'b1; fail_set = 1'b1;
        end else if (!ad_last) begin
          state_d = S_CFETCH; ad_inc = 1'b1;
        end else if (chk_lo_q) begin
          state_d = S_VCC_NOM; tmr_load = 1'b1;
        end else begin
          state_d = S_VCC_LOW; tmr_load = 1'b1; lo_set = 1'b1; ad_clr = 1'b1;
        end
      end
      S_VCC_LOW: if (tmr_exp) state_d = S_CFETCH;
      S_VCC_NOM: if (tmr_exp) state_d = S_END;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q     <= S_IDLE;
      data_q      <= '0;
      over_q      <= 1'b0;
      chk_lo_q    <= 1'b0;
      fail_q      <= 1'b0;
      fail_addr_q <= '0;
    end else begin
      state_q <= state_d;
      if (data_en) data_q <= src_data;
      if (run_clr || over_clr) over_q <= 1'b0;
      else if (over_set)       over_q <= 1'b1;
      if (run_clr || lo_clr)   chk_lo_q <= 1'b0;
      else if (lo_set)         chk_lo_q <= 1'b1;
      if (run_clr)             fail_q <= 1'b0;
      else if (fail_set)       fail_q <= 1'b1;
      if (fail_set && !fail_q) fail_addr_q <= mem_addr;
    end
  end

  always_comb begin
    mem_ce_n  = !(state_q inside {S_SETUP, S_PULSE, S_HOLD, S_RECOV, S_VERIFY, S_FLOAT, S_CREAD});
    mem_oe_n  = !(state_q inside {S_VERIFY, S_CREAD});
    mem_pgm_n = (state_q != S_PULSE);
    mem_drive = state_q inside {S_SETUP, S_PULSE, S_HOLD};
    vpp_on    = state_q inside {S_PWR_VPP, S_FETCH, S_SETUP, S_PULSE, S_HOLD, S_RECOV,
                                S_VERIFY, S_FLOAT};
    if (state_q inside {S_IDLE, S_END, S_VCC_NOM})                        vcc_sel = VCC_NOMINAL;
    else if (state_q == S_VCC_LOW)                                        vcc_sel = VCC_LOWLVL;
    else if (chk_lo_q && (state_q inside {S_CFETCH, S_CREAD}))            vcc_sel = VCC_LOWLVL;
    else                                                                  vcc_sel = VCC_PROGLVL;
    src_req   = state_q inside {S_FETCH, S_CFETCH};
    busy      = !(state_q inside {S_IDLE, S_END});
    done      = (state_q == S_END);
    pass      = done && !fail_q;
  end

  assign mem_wdata = data_q;
  assign fail      = fail_q;
  assign fail_addr = fail_addr_q;

  p_vpp_needs_core_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    vpp_on |-> (vcc_sel == VCC_PROGLVL));
  p_core_held_at_vpp_fall_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    $fell(vpp_on) |-> (vcc_sel == VCC_PROGLVL));
  p_strobe_context_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    !mem_pgm_n |-> (!mem_ce_n && vpp_on && mem_drive));
  p_strobe_stable_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!mem_pgm_n && $past(!mem_pgm_n)) |-> ($stable(mem_wdata) && $stable(mem_addr)));
  p_bus_free_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    !mem_oe_n |-> !mem_drive);
  p_skip_erased_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    !mem_pgm_n |-> (mem_wdata != '1));
  p_fail_addr_held_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    (fail_q && $past(fail_q)) |-> $stable(fail_addr_q));
  p_req_held_r11: assert property (@(posedge clk) disable iff (!rst_core_n)
    (src_req && !src_ack) |=> (src_req && $stable(mem_addr)));

endmodule

// File: tb/tb_prog_seq.sv
`timescale 1ns/1ps
module tb_prog_seq;

  localparam int AW = 3, DW = 8, SET = 4, PUL = 10, RD = 3, MAXT = 25, OM = 3;
  localparam int NB = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n, start, src_req, src_ack;
  logic [DW-1:0] src_data, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr, fail_addr;
  logic          mem_drive, mem_ce_n, mem_oe_n, mem_pgm_n, vpp_on;
  logic [1:0]    vcc_sel;
  logic          busy, done, pass, fail;

  prog_seq #(.ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(SET), .PULSE_CYC(PUL), .READ_CYC(RD),
             .MAX_TRIES(MAXT), .OVER_MULT(OM)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_req(src_req), .src_ack(src_ack),
    .src_data(src_data), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_drive(mem_drive),
    .mem_rdata(mem_rdata), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_pgm_n(mem_pgm_n),
    .vpp_on(vpp_on), .vcc_sel(vcc_sel), .busy(busy), .done(done), .pass(pass), .fail(fail),
    .fail_addr(fail_addr));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;

  // stimulus tables (written by tasks only)
  logic [DW-1:0] bufm [NB];
  int            need [NB];
  logic          weak_en;
  logic [AW-1:0] weak_a;
  logic          clr_model;

  // model and monitor state (written by the monitor only)
  logic [DW-1:0] cells [NB];
  int            pcnt [NB];
  int            sumw [NB];
  int            lastw [NB];
  int            since, rcnt, osince, vsince, psince, cur_w;
  int            viol_setup, viol_hold, viol_pwr, acks, lo_reads;
  logic [15:0]   prev_set, cur_set;
  logic          prev_pgm, prev_drive, prev_oe, prev_vpp;
  logic [1:0]    prev_vcc;

  assign mem_rdata = (!mem_ce_n && !mem_oe_n) ?
    (cells[mem_addr] ^ ((weak_en && vcc_sel == 2'b10 && mem_addr == weak_a) ? 8'h01 : 8'h00)) :
    8'hFF;

  always @(negedge clk) begin
    cur_set = {mem_addr, mem_wdata, mem_drive, mem_ce_n, vpp_on, vcc_sel};
    if (clr_model) begin
      for (int i = 0; i < NB; i++) begin
        cells[i] = 8'hFF; pcnt[i] = 0; sumw[i] = 0; lastw[i] = 0;
      end
      since = 0; rcnt = 1000; osince = 1000; vsince = 1000; psince = 1000; cur_w = 0;
      viol_setup = 0; viol_hold = 0; viol_pwr = 0; acks = 0; lo_reads = 0;
      src_ack <= 1'b0;
      src_data <= 8'h00;
    end else begin
      since  = (cur_set != prev_set) ? 0 : since + 1;
      vsince = (vcc_sel != prev_vcc) ? 0 : vsince + 1;
      psince = vpp_on ? 0 : psince + 1;
      if (!mem_pgm_n && prev_pgm) begin
        if (since < SET) viol_setup++;
        cur_w = 0;
      end
      if (!mem_pgm_n) cur_w++;
      if (mem_pgm_n && !prev_pgm) begin
        pcnt[mem_addr]++;
        sumw[mem_addr] += cur_w;
        lastw[mem_addr] = cur_w;
        if (!mem_ce_n && vpp_on && vcc_sel == 2'b01 && pcnt[mem_addr] >= need[mem_addr])
          cells[mem_addr] = cells[mem_addr] & mem_wdata;
      end
      rcnt   = !mem_pgm_n ? 0 : rcnt + 1;
      osince = !mem_oe_n ? 0 : osince + 1;
      if (!mem_drive && prev_drive && rcnt <= SET) viol_hold++;
      if (!mem_oe_n && prev_oe && vpp_on && rcnt <= 2*SET) viol_hold++;
      if (mem_drive && !prev_drive && osince <= RD) viol_hold++;
      if (vpp_on && !prev_vpp && vsince < SET) viol_pwr++;
      if (vcc_sel != prev_vcc && prev_vcc == 2'b01 && psince < SET) viol_pwr++;
      if (vpp_on && vcc_sel != 2'b01) viol_pwr++;
      if (!mem_oe_n && prev_oe && vcc_sel == 2'b10) lo_reads++;
      if (src_ack) acks++;
      src_ack  <= src_req && !src_ack;
      src_data <= bufm[mem_addr];
    end
    prev_set = cur_set; prev_pgm = mem_pgm_n; prev_drive = mem_drive;
    prev_oe = mem_oe_n; prev_vpp = vpp_on; prev_vcc = vcc_sel;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act,
                     input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic load_case();
    bufm[0] = 8'h12; bufm[1] = 8'h00; bufm[2] = 8'hFF; bufm[3] = 8'hA5;
    bufm[4] = 8'h3C; bufm[5] = 8'h7E; bufm[6] = 8'h81; bufm[7] = 8'hC3;
    for (int i = 0; i < NB; i++) need[i] = 1;
    weak_en = 1'b0; weak_a = '0;
  endtask

  task automatic run_once();
    clr_model = 1'b1;
    repeat (2) @(negedge clk);
    clr_model = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
    chk(done == 1'b1, "R10", "run completes", int'(done), 1);
    chk(!vpp_on && vcc_sel == 2'b00, "R10", "supplies parked {vpp,vcc}",
        int'({vpp_on, vcc_sel}), 0);
  endtask

  task automatic t_reset();
    chk(mem_ce_n && mem_oe_n && mem_pgm_n, "R1", "controls high {ce,oe,pgm}",
        int'({mem_ce_n, mem_oe_n, mem_pgm_n}), 7);
    chk(!mem_drive && !vpp_on && vcc_sel == 2'b00, "R1", "drive/vpp/vcc",
        int'({mem_drive, vpp_on, vcc_sel}), 0);
    chk(!busy && !done && !fail && !src_req, "R1", "status {busy,done,fail,req}",
        int'({busy, done, fail, src_req}), 0);
  endtask

  task automatic t_basic();
    int bad_w = 0, bad_c = 0;
    load_case();
    run_once();
    chk(pass && !fail, "R9", "clean run passes {pass,fail}", int'({pass, fail}), 2);
    for (int i = 0; i < NB; i++) begin
      if (cells[i] != bufm[i]) bad_c++;
      if (i != 2 && (pcnt[i] != 2 || sumw[i] != PUL + OM*PUL || lastw[i] != OM*PUL)) bad_w++;
    end
    chk(bad_c == 0, "R4", "cells programmed, mismatches", bad_c, 0);
    chk(bad_w == 0, "R7", "pulse+over widths, bad addresses", bad_w, 0);
    chk(pcnt[2] == 0, "R8", "erased byte pulses", pcnt[2], 0);
    chk(viol_setup == 0, "R3", "setup violations", viol_setup, 0);
    chk(viol_hold == 0, "R5", "hold/bus violations", viol_hold, 0);
    chk(viol_pwr == 0, "R2", "supply order violations", viol_pwr, 0);
    chk(acks == 3*NB, "R11", "source handshakes", acks, 3*NB);
    chk(lo_reads == NB, "R9", "reads at low core level", lo_reads, NB);
  endtask

  task automatic t_retry();
    load_case();
    need[5] = 4;
    run_once();
    chk(pass, "R6", "retry run passes", int'(pass), 1);
    chk(pcnt[5] == 5, "R6", "pulses at retry address", pcnt[5], 5);
    chk(sumw[5] - lastw[5] == 4*PUL, "R4", "normal pulse time", sumw[5] - lastw[5], 4*PUL);
    chk(lastw[5] == OM*4*PUL, "R7", "over pulse scaled by n", lastw[5], OM*4*PUL);
    chk(lastw[6] == OM*PUL, "R4", "n restarts at 1 for next address", lastw[6], OM*PUL);
  endtask

  task automatic t_exhaust();
    load_case();
    need[3] = MAXT + 1;
    run_once();
    chk(fail && !pass, "R6", "exhausted tries fail {fail,pass}", int'({fail, pass}), 2);
    chk(pcnt[3] == MAXT, "R6", "pulses at stuck address", pcnt[3], MAXT);
    chk(pcnt[4] == 0, "R6", "no pulses after failure", pcnt[4], 0);
    chk(fail_addr == 3'd3, "R10", "first failing address", int'(fail_addr), 3);
    chk(viol_pwr == 0, "R2", "supply order on fail path", viol_pwr, 0);
  endtask

  task automatic t_weak();
    load_case();
    weak_en = 1'b1; weak_a = 3'd6;
    run_once();
    chk(fail && !pass, "R9", "low-level mismatch fails", int'({fail, pass}), 2);
    chk(fail_addr == 3'd6, "R10", "weak address reported", int'(fail_addr), 6);
    chk(lo_reads == 7, "R9", "low-level reads before stop", lo_reads, 7);
    @(negedge clk);
    chk(fail && fail_addr == 3'd6, "R10", "fail address latched", int'(fail_addr), 6);
  endtask

  initial begin
    clr_model = 1'b1;
    start = 1'b0;
    rst_n = 1'b0;
    load_case();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    clr_model = 1'b0;
    t_reset();
    t_basic();
    t_retry();
    t_exhaust();
    t_weak();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule